// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control-register front end of an audio codec. A simple word-addressed bus with separate read and write strobes reaches sixteen 32-bit direct registers. One of them is a data window into a second bank of thirty-two 8-bit registers. The window entry is chosen by an index held in the low five bits of direct register 0. Some indices hide their contents on read, some refuse writes, and one merges a single writable bit with a fixed codec identification code.

Software can restore the default contents of both banks by writing direct register 4 with bit 0 set. The active-low asynchronous reset input loads the same defaults. Reads are combinational from the stored state and return data in the same cycle as the read strobe. Writes take effect at the rising clock edge. The interrupt output exists for system integration and is held low.

Top module: `codec_ctrl_regs`

## Requirements
- R1: After reset every direct register and every indexed register reads zero, except indexed entry 12, which reads 0x8A, and indexed entry 25, which reads 0xA0.
- R2: A write to a direct register other than words 1, 2 and 4 stores all 32 bits, and a later read returns them. The word is selected by address bits [5:2], and address bits [1:0] have no effect.
- R3: The current index is bits [4:0] of direct register 0. A read of word 1 returns the selected indexed byte in bits [7:0], with bits [31:8] zero.
- R4: A write to word 1 at any ordinary index stores bits [7:0] of the write data into the selected indexed entry.
- R5: A read of word 1 while the index is 3 returns zero, whatever was written there.
- R6: Writes to word 1 while the index is 11 or 25 leave those entries unchanged.
- R7: A write to word 1 at index 12 stores (data AND 0x40) OR 0x8A.
- R8: Writes to word 2 are ignored, and word 2 always reads zero.
- R9: A write to word 4 stores the write data AND 0x7F. If bit 0 of the write data is 1, both banks first return to their R1 defaults, and word 4 then holds the masked value. If bit 0 is 0, no other register changes.
- R10: The interrupt output is always 0.
- R11: While the read strobe is low, the read data bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, loads defaults |
| bus_addr | input | 6 | Byte address; bits [5:2] pick the word |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq_o | output | 1 | Interrupt request, held low |

## Verification
The properties assume that read and write strobes are never raised in the same cycle. They also assume that address and data stay steady from just after one rising edge through the next. The next-cycle checks on the index and on the control word rely on the write having completed at the edge they are sampled from. The stimulus changes inputs shortly after each rising edge, issues exactly one bus operation per task call, and always drops the strobe before starting the next operation.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;

  // direct word roles
  localparam int W_INDEX  = 0;
  localparam int W_WINDOW = 1;
  localparam int W_LOCKED = 2;
  localparam int W_CTRL   = 4;

  // indexed entry roles
  localparam int X_HIDDEN = 3;
  localparam int X_FIXED0 = 11;
  localparam int X_IDENT  = 12;
  localparam int X_CHIP   = 25;

  localparam logic [BYTE_W-1:0] IDENT_CODE = 8'h8A;
  localparam logic [BYTE_W-1:0] CHIP_CODE  = 8'hA0;
  localparam logic [BYTE_W-1:0] IDENT_KEEP = 8'h40;
  localparam logic [BUS_W-1:0]  CTRL_KEEP  = 32'h0000_007F;

  function automatic logic [BYTE_W-1:0] idx_default(input int k);
    if (k == X_IDENT)     return IDENT_CODE;
    else if (k == X_CHIP) return CHIP_CODE;
    else                  return '0;
  endfunction

  function automatic logic idx_accepts_write(input int k);
    return !(k == X_FIXED0 || k == X_CHIP);
  endfunction

  function automatic logic idx_hides_read(input int k);
    return (k == X_HIDDEN);
  endfunction

  function automatic logic [BYTE_W-1:0] idx_store_val(input int k,
                                                      input logic [BYTE_W-1:0] w);
    if (k == X_IDENT) return (w & IDENT_KEEP) | IDENT_CODE;
    else              return w;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_store_val(input logic [BUS_W-1:0] w);
    return w & CTRL_KEEP;
  endfunction

endpackage

// File: rtl/codec_bus_decode.sv
module codec_bus_decode
  import codec_regs_pkg::*;
#(
  parameter int WORD_W = 4,
  localparam int ADDR_W = WORD_W + 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              wbit0,
  output logic [WORD_W-1:0] word,
  output logic              dir_wr,
  output logic              win_wr,
  output logic              win_rd,
  output logic              soft_rst
);

  logic unused_lo;
  assign unused_lo = ^addr[1:0];

  assign word = addr[ADDR_W-1:2];

  logic hit_win, hit_lock, hit_ctrl;
  assign hit_win  = (word == WORD_W'(W_WINDOW));
  assign hit_lock = (word == WORD_W'(W_LOCKED));
  assign hit_ctrl = (word == WORD_W'(W_CTRL));

  assign win_wr   = wr && hit_win;
  assign win_rd   = rd && hit_win;
  assign dir_wr   = wr && !hit_win && !hit_lock;
  assign soft_rst = wr && hit_ctrl && wbit0;

endmodule

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regs_pkg::*;
#(
  parameter int DIR_CNT = 16,
  parameter int IDX_W   = 5,
  localparam int WORD_W = $clog2(DIR_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [BUS_W-1:0]  wr_val,
  input  logic [WORD_W-1:0] rd_word,
  output logic [BUS_W-1:0]  rd_val,
  output logic [IDX_W-1:0]  cur_index,
  output logic [BUS_W-1:0]  ctl_q
);

  logic [BUS_W-1:0] dq [DIR_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DIR_CNT; k++) dq[k] <= '0;
    end else begin
      for (int k = 0; k < DIR_CNT; k++) begin
        if (soft_rst) dq[k] <= '0;
        if (wr_en && wr_word == WORD_W'(k)) dq[k] <= wr_val;
      end
    end
  end

  assign rd_val    = dq[rd_word];
  assign cur_index = dq[W_INDEX][IDX_W-1:0];
  assign ctl_q     = dq[W_CTRL];

endmodule

// File: rtl/codec_index_bank.sv
module codec_index_bank
  import codec_regs_pkg::*;
#(
  parameter int IND_CNT = 32,
  localparam int IDX_W  = $clog2(IND_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte
);

  logic [BYTE_W-1:0] xq [IND_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < IND_CNT; k++) xq[k] <= idx_default(k);
    end else begin
      for (int k = 0; k < IND_CNT; k++) begin
        if (soft_rst) xq[k] <= idx_default(k);
        else if (wr_en && idx == IDX_W'(k) && idx_accepts_write(k))
          xq[k] <= idx_store_val(k, wr_byte);
      end
    end
  end

  assign rd_byte = idx_hides_read(int'(idx)) ? '0 : xq[idx];

endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
  import codec_regs_pkg::*;
#(
  parameter int DIR_CNT = 16,
  parameter int IND_CNT = 32,
  localparam int WORD_W = $clog2(DIR_CNT),
  localparam int ADDR_W = WORD_W + 2,
  localparam int IDX_W  = $clog2(IND_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);

  logic [WORD_W-1:0] word;
  logic              dir_wr, win_wr, win_rd, soft_rst_evt;
  logic [BUS_W-1:0]  dir_wval, dir_rd;
  logic [IDX_W-1:0]  cur_index;
  logic [BUS_W-1:0]  ctl_q;
  logic [BYTE_W-1:0] ind_rd;

  codec_bus_decode #(.WORD_W(WORD_W)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wbit0    (bus_wdata[0]),
    .word     (word),
    .dir_wr   (dir_wr),
    .win_wr   (win_wr),
    .win_rd   (win_rd),
    .soft_rst (soft_rst_evt)
  );

  assign dir_wval = (word == WORD_W'(W_CTRL)) ? ctrl_store_val(bus_wdata) : bus_wdata;

  codec_direct_bank #(.DIR_CNT(DIR_CNT), .IDX_W(IDX_W)) u_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst_evt),
    .wr_en     (dir_wr),
    .wr_word   (word),
    .wr_val    (dir_wval),
    .rd_word   (word),
    .rd_val    (dir_rd),
    .cur_index (cur_index),
    .ctl_q     (ctl_q)
  );

  codec_index_bank #(.IND_CNT(IND_CNT)) u_ind (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst_evt),
    .wr_en    (win_wr),
    .idx      (cur_index),
    .wr_byte  (bus_wdata[BYTE_W-1:0]),
    .rd_byte  (ind_rd)
  );

  always_comb begin
    if (!bus_rd)                         bus_rdata = '0;
    else if (win_rd)                     bus_rdata = {{(BUS_W-BYTE_W){1'b0}}, ind_rd};
    else if (word == WORD_W'(W_LOCKED))  bus_rdata = '0;
    else                                 bus_rdata = dir_rd;
  end

  assign irq_o = 1'b0;

endmodule

// File: rtl/codec_ctrl_regs_chk.sv
module codec_ctrl_regs_chk
  import codec_regs_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int IDX_W  = 5,
  localparam int ADDR_W = WORD_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq_o,
  input logic              soft_rst_evt,
  input logic [IDX_W-1:0]  cur_index,
  input logic [BUS_W-1:0]  ctl_q
);

  logic [WORD_W-1:0] w;
  logic              wrd;
  assign w   = bus_addr[ADDR_W-1:2];
  assign wrd = bus_rd && (w == WORD_W'(W_WINDOW));

  // R10
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n) irq_o == 1'b0);

  // R11
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

  // R8
  a_r8_locked_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && w == WORD_W'(W_LOCKED)) |-> bus_rdata == '0);

  // R5
  a_r5_hidden_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (wrd && cur_index == IDX_W'(X_HIDDEN)) |-> bus_rdata == '0);

  // R6
  a_r6_fixed0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrd && cur_index == IDX_W'(X_FIXED0)) |-> bus_rdata == '0);
  a_r6_chip_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wrd && cur_index == IDX_W'(X_CHIP)) |-> bus_rdata == {24'h0, CHIP_CODE});

  // R7
  a_r7_ident_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (wrd && cur_index == IDX_W'(X_IDENT)) |->
      (bus_rdata[BUS_W-1:BYTE_W] == '0 && (bus_rdata[BYTE_W-1:0] & ~IDENT_KEEP) == IDENT_CODE));

  // R3
  a_r3_index_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && w == WORD_W'(W_INDEX)) |=> cur_index == $past(bus_wdata[IDX_W-1:0]));

  // R9
  a_r9_soft_clears_index: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_evt |=> cur_index == '0);
  a_r9_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && w == WORD_W'(W_CTRL)) |=> ctl_q == ($past(bus_wdata) & CTRL_KEEP));

endmodule

bind codec_ctrl_regs codec_ctrl_regs_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .irq_o        (irq_o),
  .soft_rst_evt (soft_rst_evt),
  .cur_index    (cur_index),
  .ctl_q        (ctl_q)
);

// File: tb/tb_codec_ctrl_regs.sv
`timescale 1ns/1ps
module tb_codec_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  codec_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic void judge(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endfunction

  // monitor: pops expected items while a read is in flight
  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        judge("monitor-empty-queue", 32'h1, 32'h0);
      end else begin
        judge(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
      judge("R10 irq", {31'h0, irq_o}, 32'h0);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic sel(input int k);
    wr(6'h00, 32'(k));
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 5) & 8'hFF);
  endfunction

  function automatic bit special(input int k);
    return (k == 3 || k == 11 || k == 12 || k == 25);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 defaults
    rd(6'h00, 32'h0, "R1 index word");
    rd(6'h0C, 32'h0, "R1 word3");
    rd(6'h3C, 32'h0, "R1 word15");
    rd(6'h04, 32'h0, "R1 entry0");
    sel(12); rd(6'h04, 32'h8A, "R1 entry12");
    sel(25); rd(6'h04, 32'hA0, "R1 entry25");
    sel(7);  rd(6'h04, 32'h0, "R1 entry7");

    // R11 idle bus
    @(negedge clk);
    judge("R11 idle rdata", bus_rdata, 32'h0);
    judge("R10 irq idle", {31'h0, irq_o}, 32'h0);

    // R2 direct storage, low address bits ignored
    wr(6'h14, 32'hDEAD_BEEF);
    rd(6'h14, 32'hDEAD_BEEF, "R2 word5");
    rd(6'h17, 32'hDEAD_BEEF, "R2 word5 low bits");
    wr(6'h3E, 32'h1234_5678);
    rd(6'h3C, 32'h1234_5678, "R2 word15");

    // R3 index from low 5 bits
    wr(6'h00, 32'hFFFF_FFE7);
    rd(6'h00, 32'hFFFF_FFE7, "R2 index word full");
    wr(6'h04, 32'hABCD_EF5A);
    rd(6'h04, 32'h0000_005A, "R3 window entry7");
    sel(7);
    rd(6'h04, 32'h0000_005A, "R3 reselect entry7");

    // R4 ordinary entries
    for (int k = 0; k < 32; k++) begin
      if (!special(k)) begin
        sel(k);
        wr(6'h04, {24'hFFFFFF, pat(k)});
      end
    end
    for (int k = 0; k < 32; k++) begin
      if (!special(k)) begin
        sel(k);
        rd(6'h04, {24'h0, pat(k)}, $sformatf("R4 entry%0d", k));
      end
    end

    // R5 hidden entry
    sel(3); wr(6'h04, 32'hFF);
    rd(6'h04, 32'h0, "R5 entry3 hidden");

    // R6 read-only entries
    sel(11); wr(6'h04, 32'h55);
    rd(6'h04, 32'h0, "R6 entry11");
    sel(25); wr(6'h04, 32'h00);
    rd(6'h04, 32'hA0, "R6 entry25");

    // R7 merged identity entry
    sel(12);
    wr(6'h04, 32'hFF); rd(6'h04, 32'hCA, "R7 all ones");
    wr(6'h04, 32'h00); rd(6'h04, 32'h8A, "R7 zero");
    wr(6'h04, 32'h35); rd(6'h04, 32'h8A, "R7 bit6 clear");
    wr(6'h04, 32'h40); rd(6'h04, 32'hCA, "R7 bit6 set");

    // R8 locked word
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, 32'h0, "R8 word2");

    // R9 control word without reset bit
    wr(6'h10, 32'h0000_00FE);
    rd(6'h10, 32'h0000_007E, "R9 ctrl masked");
    rd(6'h14, 32'hDEAD_BEEF, "R9 word5 untouched");
    sel(9);
    rd(6'h04, {24'h0, pat(9)}, "R9 entry9 untouched");

    // R9 control word with reset bit
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0000_007F, "R9 ctrl after reset");
    rd(6'h14, 32'h0, "R9 word5 cleared");
    rd(6'h3C, 32'h0, "R9 word15 cleared");
    rd(6'h00, 32'h0, "R9 index cleared");
    rd(6'h04, 32'h0, "R9 entry0 cleared");
    sel(12); rd(6'h04, 32'h8A, "R9 entry12 default");
    sel(25); rd(6'h04, 32'hA0, "R9 entry25 default");
    sel(9);  rd(6'h04, 32'h0, "R9 entry9 cleared");

    @(negedge clk);
    judge("R11 idle end", bus_rdata, 32'h0);

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule